// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block issues one short command to a serial flash device over a single-lane SPI link. Software writes one packed 32-bit control word. The word holds the opcode and turns on, and sizes, each optional phase that follows it: address bytes, dummy clocks, write bytes and read bytes. Setting the start bit while the block is idle launches the sequence. The address value and up to eight write bytes come from plain 32-bit inputs. Up to eight received bytes are returned on two 32-bit outputs.

The serial clock is paced by an external bit-tick strobe. Each tick moves the clock by one half period, so one full clock period takes two ticks. Before the first clock edge the block requests the chip select and waits for a grant. It releases the request when the last bit has gone out. A busy flag is visible in the status readback for the whole sequence. Any start request that arrives while a sequence runs is ignored.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the status readback is zero, csReq and sclk are low, and both read-data outputs are zero.
- R2: A control write with bit 0 set while idle starts a command. Status bit 1 (busy) reads 1 in the next cycle and csReq rises in that same cycle.
- R3: The first phase is the opcode in control bits 31:24, sent MSB first on mosi. mosi is sampled by the device on each rising sclk edge (clock idles low).
- R4: When bit 19 is set, N address bytes follow, where N−1 sits in bits 17:16. They are the N low-order bytes of cmdAddr, most significant of those first, each byte MSB first.
- R5: A nonzero value D in bits 11:7 inserts D sclk periods after the address, with mosi held low.
- R6: When bit 15 is set, N write bytes follow, where N−1 sits in bits 14:12. They are taken from wrDataLo byte 0 (bits 7:0) upward, then wrDataHi byte 0 upward, each byte MSB first.
- R7: When bit 23 is set, N bytes are read, where N−1 sits in bits 22:20. miso is captured MSB first on rising sclk. Received byte k lands in bits 8k+7:8k of {rdDataHi, rdDataLo}. Bytes not read in a command read as zero after it.
- R8: Phases run in the fixed order opcode, address, dummy, write, read. Disabled phases are skipped. The total number of rising sclk edges equals 8 + 8·addr + dummy + 8·write + 8·read.
- R9: After the last bit, busy clears and csReq falls, and sclk rests low.
- R10: A start write while busy is ignored. The status readback bits 31:2 keep the running command's word, and no further clock edges follow the running command.
- R11: sclk stays low until csGnt is seen, and it changes level only in a cycle that follows a bitTick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word value; bit 0 requests start |
| ctrlStatus | output | 32 | Readback: bits 31:2 of the stored word, bit 1 busy, bit 0 zero |
| cmdAddr | input | 32 | Address value for the address phase |
| wrDataLo | input | 32 | Write bytes 0 to 3 |
| wrDataHi | input | 32 | Write bytes 4 to 7 |
| rdDataLo | output | 32 | Read bytes 0 to 3 |
| rdDataHi | output | 32 | Read bytes 4 to 7 |
| bitTick | input | 1 | Half-period pacing strobe for sclk |
| csReq | output | 1 | Chip-select request, high for the whole command |
| csGnt | input | 1 | Chip-select grant |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
Directed words cover the following cases:
- opcode alone, which shows that empty phases are skipped;
- one-byte and four-byte addresses, which separate low-order byte choice from byte order;
- the largest dummy count, next to a zero count;
- single-byte and eight-byte writes and reads, which expose errors in register-lane and byte-order mapping, plus a short read that must leave the upper bytes at zero.

Random control words, tick spacings and grant delays then mix the phases in combinations no directed case reaches. One command receives a start write while it waits for its grant. This separates a block that ignores the write from one that restarts or changes its configuration.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CTRL_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int MAX_BYTES  = 8;
  localparam int IDX_W      = $clog2(MAX_BYTES);
  localparam int DMY_W      = 5;
  localparam int ADR_CNT_W  = 2;
  localparam int DATA_W     = BYTE_W * MAX_BYTES;

  // control word layout (decoded by software, so positions are fixed)
  localparam int OPC_LSB    = 24;
  localparam int RD_EN_BIT  = 23;
  localparam int RD_CNT_LSB = 20;
  localparam int ADR_EN_BIT = 19;
  localparam int ADR_CNT_LSB= 16;
  localparam int WR_EN_BIT  = 15;
  localparam int WR_CNT_LSB = 12;
  localparam int DMY_LSB    = 7;
  localparam int BUSY_BIT   = 1;
  localparam int START_BIT  = 0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ACQ, PH_OPC, PH_ADR, PH_DMY, PH_WR, PH_RD
  } phase_e;

  typedef enum logic [1:0] {SRC_ZERO, SRC_OPC, SRC_ADR, SRC_WR} src_e;

  typedef struct packed {
    logic             latch;
    logic             load;
    src_e             src;
    logic [IDX_W-1:0] sel;
    logic             sample;
    logic             shift;
    logic             store;
    logic [IDX_W-1:0] storeIdx;
  } dp_strobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              bitTick,
  input  logic              csGnt,
  output logic [CTRL_W-1:0] cfgWord,
  output logic              busy,
  output logic              sclk,
  output dp_strobe_t        stb
);
  phase_e            state;
  logic [CTRL_W-1:0] cfg;
  logic              sclkQ;
  logic [2:0]        bitCnt;
  logic [IDX_W-1:0]  byteIdx;
  logic [DMY_W-1:0]  dmyLeft;

  logic                 addrEn, wrEn, rdEn;
  logic [ADR_CNT_W-1:0] addrLast;
  logic [IDX_W-1:0]     wrLast, rdLast, lastIdx;
  logic [DMY_W-1:0]     dmyN;
  logic shifting, rise, fall, unitEnd, phaseEnd, startOk;
  phase_e nxt;

  assign addrEn   = cfg[ADR_EN_BIT];
  assign addrLast = cfg[ADR_CNT_LSB +: ADR_CNT_W];
  assign wrEn     = cfg[WR_EN_BIT];
  assign wrLast   = cfg[WR_CNT_LSB +: IDX_W];
  assign rdEn     = cfg[RD_EN_BIT];
  assign rdLast   = cfg[RD_CNT_LSB +: IDX_W];
  assign dmyN     = cfg[DMY_LSB +: DMY_W];

  assign busy    = (state != PH_IDLE);
  assign sclk    = sclkQ;
  assign cfgWord = cfg;
  assign startOk = ctrlWrEn && ctrlWrData[START_BIT] && (state == PH_IDLE);

  function automatic src_e srcOf(input phase_e p);
    case (p)
      PH_OPC:  srcOf = SRC_OPC;
      PH_ADR:  srcOf = SRC_ADR;
      PH_WR:   srcOf = SRC_WR;
      default: srcOf = SRC_ZERO;
    endcase
  endfunction

  always_comb begin
    // earliest enabled phase after the current one
    nxt = PH_IDLE;
    if (rdEn && (state < PH_RD))            nxt = PH_RD;
    if (wrEn && (state < PH_WR))            nxt = PH_WR;
    if ((dmyN != '0) && (state < PH_DMY))   nxt = PH_DMY;
    if (addrEn && (state < PH_ADR))         nxt = PH_ADR;

    case (state)
      PH_ADR:  lastIdx = IDX_W'(addrLast);
      PH_WR:   lastIdx = wrLast;
      PH_RD:   lastIdx = rdLast;
      default: lastIdx = '0;
    endcase

    shifting = (state == PH_OPC) || (state == PH_ADR) || (state == PH_DMY) ||
               (state == PH_WR)  || (state == PH_RD);
    rise     = shifting && bitTick && !sclkQ;
    fall     = shifting && bitTick && sclkQ;
    unitEnd  = (state == PH_DMY) ? (dmyLeft == DMY_W'(1)) : (bitCnt == 3'd7);
    phaseEnd = (state == PH_DMY) || (byteIdx == lastIdx);

    stb        = '0;
    stb.latch  = startOk;
    stb.sample = rise && (state == PH_RD);
    stb.shift  = fall && !unitEnd && (state != PH_DMY);
    if ((state == PH_ACQ) && csGnt) begin
      stb.load = 1'b1;
      stb.src  = SRC_OPC;
    end
    if (fall && unitEnd) begin
      stb.store    = (state == PH_RD);
      stb.storeIdx = byteIdx;
      if (phaseEnd) begin
        stb.load = (nxt != PH_IDLE);
        stb.src  = srcOf(nxt);
        stb.sel  = (nxt == PH_ADR) ? IDX_W'(addrLast) : '0;
      end else begin
        stb.load = 1'b1;
        stb.src  = srcOf(state);
        stb.sel  = (state == PH_ADR) ? IDX_W'(addrLast) - byteIdx - IDX_W'(1)
                                     : byteIdx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      cfg     <= '0;
      sclkQ   <= 1'b0;
      bitCnt  <= '0;
      byteIdx <= '0;
      dmyLeft <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (ctrlWrEn) cfg <= {ctrlWrData[CTRL_W-1:2], 2'b00};
          if (startOk)  state <= PH_ACQ;
        end
        PH_ACQ: begin
          if (csGnt) begin
            state   <= PH_OPC;
            bitCnt  <= '0;
            byteIdx <= '0;
            dmyLeft <= dmyN;
          end
        end
        default: begin
          if (rise) sclkQ <= 1'b1;
          if (fall) begin
            sclkQ <= 1'b0;
            if (unitEnd) begin
              bitCnt <= '0;
              if (phaseEnd) begin
                state   <= nxt;
                byteIdx <= '0;
              end else begin
                byteIdx <= byteIdx + IDX_W'(1);
              end
            end else if (state == PH_DMY) begin
              dmyLeft <= dmyLeft - DMY_W'(1);
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end
      endcase
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> busy);
  // R9
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkQ);
  // R11
  clk_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ != $past(sclkQ)) |-> $past(bitTick));
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cfg));
endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [CTRL_W-1:0] addrIn,
  input  logic [CTRL_W-1:0] wrLo,
  input  logic [CTRL_W-1:0] wrHi,
  input  logic              sclk,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData
);
  logic [CTRL_W-1:0] addrQ;
  logic [DATA_W-1:0] wrQ;
  logic [BYTE_W-1:0] txQ, rxQ, loadByte;

  always_comb begin
    case (stb.src)
      SRC_OPC: loadByte = opcode;
      SRC_ADR: loadByte = addrQ[stb.sel[1:0]*BYTE_W +: BYTE_W];
      SRC_WR:  loadByte = wrQ[stb.sel*BYTE_W +: BYTE_W];
      default: loadByte = '0;
    endcase
  end

  assign mosi = txQ[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wrQ   <= '0;
      txQ   <= '0;
      rxQ   <= '0;
    end else begin
      if (stb.latch) begin
        addrQ <= addrIn;
        wrQ   <= {wrHi, wrLo};
      end
      if (stb.load)       txQ <= loadByte;
      else if (stb.shift) txQ <= {txQ[BYTE_W-2:0], 1'b0};
      if (stb.sample)     rxQ <= {rxQ[BYTE_W-2:0], miso};
    end
  end

  for (genvar lane = 0; lane < MAX_BYTES; lane++) begin : g_rdLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          rdData[lane*BYTE_W +: BYTE_W] <= '0;
      else if (stb.latch)                                 rdData[lane*BYTE_W +: BYTE_W] <= '0;
      else if (stb.store && (stb.storeIdx == IDX_W'(lane))) rdData[lane*BYTE_W +: BYTE_W] <= rxQ;
    end
  end

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  output logic [31:0] ctrlStatus,
  input  logic [31:0] cmdAddr,
  input  logic [31:0] wrDataLo,
  input  logic [31:0] wrDataHi,
  output logic [31:0] rdDataLo,
  output logic [31:0] rdDataHi,
  input  logic        bitTick,
  output logic        csReq,
  input  logic        csGnt,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  dp_strobe_t        stb;
  logic [CTRL_W-1:0] cfgWord;
  logic              busy;
  logic [DATA_W-1:0] rdData;

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .bitTick(bitTick), .csGnt(csGnt), .cfgWord(cfgWord), .busy(busy),
    .sclk(sclk), .stb(stb)
  );

  flash_cmd_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opcode(cfgWord[OPC_LSB +: BYTE_W]),
    .addrIn(cmdAddr), .wrLo(wrDataLo), .wrHi(wrDataHi), .sclk(sclk),
    .miso(miso), .mosi(mosi), .rdData(rdData)
  );

  assign csReq      = busy;
  assign ctrlStatus = {cfgWord[CTRL_W-1:2], busy, 1'b0};
  assign rdDataLo   = rdData[CTRL_W-1:0];
  assign rdDataHi   = rdData[DATA_W-1:CTRL_W];
endmodule

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [31:0] ctrlStatus;
  logic [31:0] cmdAddr = '0, wrDataLo = '0, wrDataHi = '0;
  logic [31:0] rdDataLo, rdDataHi;
  logic        bitTick = 1'b0;
  logic        csReq;
  logic        csGnt = 1'b0;
  logic        sclk, mosi, miso;

  int checks = 0, fails = 0, cycles = 0;
  int tickPeriod = 1, tickCnt = 0, grantDelay = 0, gntCnt = 0;
  int capCnt = 0;
  logic expBits [0:255];
  logic capBits [0:255];
  logic respBits [0:255];

  always #5 clk = ~clk;

  flash_cmd_engine u_flash_cmd_engine (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlStatus(ctrlStatus), .cmdAddr(cmdAddr), .wrDataLo(wrDataLo),
    .wrDataHi(wrDataHi), .rdDataLo(rdDataLo), .rdDataHi(rdDataHi),
    .bitTick(bitTick), .csReq(csReq), .csGnt(csGnt), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  assign miso = respBits[capCnt];

  always @(posedge clk) begin
    if (tickCnt >= tickPeriod - 1) begin tickCnt <= 0; bitTick <= 1'b1; end
    else begin tickCnt <= tickCnt + 1; bitTick <= 1'b0; end
    if (csReq) begin gntCnt <= gntCnt + 1; csGnt <= (gntCnt >= grantDelay); end
    else begin gntCnt <= 0; csGnt <= 1'b0; end
  end

  always @(posedge sclk) begin
    if (capCnt < 256) capBits[capCnt] = mosi;
    capCnt = capCnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic pushByte(inout int n, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin expBits[n] = b[i]; n++; end
  endtask

  task automatic segCheck(input int s, input int len, input string tag);
    logic [63:0] a = '0, e = '0;
    bit ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (capBits[s+i] !== expBits[s+i]) ok = 1'b0;
      if (i < 64) begin a = {a[62:0], capBits[s+i]}; e = {e[62:0], expBits[s+i]}; end
    end
    check(ok, tag, a, e);
  endtask

  task automatic runCmd(input logic [31:0] word, input logic [31:0] addr,
                        input logic [63:0] wdat, input logic [63:0] resp,
                        input int tickP, input int gDly, input bit tryIgnore);
    int na, nd, nw, nr, n, sA, sD, sW, sR, wait_n;
    logic [63:0] expRd;
    na = word[19] ? int'(word[17:16]) + 1 : 0;
    nd = int'(word[11:7]);
    nw = word[15] ? int'(word[14:12]) + 1 : 0;
    nr = word[23] ? int'(word[22:20]) + 1 : 0;
    n = 0;
    pushByte(n, word[31:24]);
    sA = n;
    for (int k = na - 1; k >= 0; k--) pushByte(n, addr[k*8 +: 8]);
    sD = n;
    for (int k = 0; k < nd; k++) begin expBits[n] = 1'b0; n++; end
    sW = n;
    for (int k = 0; k < nw; k++) pushByte(n, wdat[k*8 +: 8]);
    sR = n;
    for (int k = 0; k < 256; k++) respBits[k] = 1'b0;
    expRd = '0;
    for (int k = 0; k < nr; k++) begin
      expRd[k*8 +: 8] = resp[k*8 +: 8];
      for (int b = 0; b < 8; b++) respBits[sR + k*8 + b] = resp[k*8 + 7 - b];
    end
    for (int k = 0; k < nr*8; k++) begin expBits[n] = 1'b0; n++; end
    tickPeriod = tickP; grantDelay = gDly;
    @(negedge clk);
    capCnt = 0;
    ctrlWrEn = 1'b1; ctrlWrData = word | 32'h1;
    cmdAddr = addr; wrDataLo = wdat[31:0]; wrDataHi = wdat[63:32];
    @(negedge clk);
    ctrlWrEn = 1'b0;
    // R2
    check(ctrlStatus[1] && csReq, "R2 busy/csReq after start", {62'd0, ctrlStatus[1], csReq}, 64'd3);
    if (tryIgnore) begin
      @(negedge clk);
      ctrlWrEn = 1'b1; ctrlWrData = ~word | 32'h1;
      @(negedge clk);
      ctrlWrEn = 1'b0;
      // R10
      check(ctrlStatus[31:2] == word[31:2], "R10 status kept during busy", {32'd0, ctrlStatus}, {32'd0, word[31:2], 2'b10});
    end
    if (gDly >= 4) begin
      // R11
      check(capCnt == 0 && !sclk, "R11 no clock before grant", {32'd0, capCnt}, 64'd0);
    end
    wait_n = 0;
    while (ctrlStatus[1] && wait_n < 20000) begin @(negedge clk); wait_n++; end
    // R8
    check(capCnt == n, "R8 total clock edges", {32'd0, capCnt}, {32'd0, n});
    // R3
    segCheck(0, 8, "R3 opcode bits");
    if (na > 0) segCheck(sA, sD - sA, "R4 address bits");
    if (nd > 0) segCheck(sD, nd, "R5 dummy bits low");
    if (nw > 0) segCheck(sW, sR - sW, "R6 write bits");
    // R7
    check({rdDataHi, rdDataLo} == expRd, "R7 read data", {rdDataHi, rdDataLo}, expRd);
    // R9
    check(!csReq && !sclk && !ctrlStatus[1], "R9 release after last bit", {61'd0, csReq, sclk, ctrlStatus[1]}, 64'd0);
    if (tryIgnore) begin
      repeat (40) @(negedge clk);
      // R10
      check(capCnt == n && !ctrlStatus[1], "R10 no second command", {32'd0, capCnt}, {32'd0, n});
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [7:0] opc, input bit rdE, input int rdN,
      input bit adE, input int adN, input bit wrE, input int wrN, input int dmy);
    mkWord = {opc, rdE, 3'(rdN), adE, 1'b0, 2'(adN), wrE, 3'(wrN), 5'(dmy), 7'd0};
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1
    check(ctrlStatus == 0 && !csReq && !sclk && rdDataLo == 0 && rdDataHi == 0,
          "R1 reset state", {ctrlStatus, 29'd0, csReq, sclk, 1'b0}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runCmd(mkWord(8'h06, 0,0, 0,0, 0,0, 0), 32'h0, 64'h0, 64'h0, 1, 0, 0);
    runCmd(mkWord(8'h9F, 1,2, 0,0, 0,0, 0), 32'h0, 64'h0, 64'hFFEE_DDCC_00C2_2018, 2, 5, 0);
    runCmd(mkWord(8'hEC, 1,7, 1,3, 0,0, 8), 32'hA1B2_C3D4, 64'h0, 64'h8877_6655_4433_2211, 1, 1, 0);
    runCmd(mkWord(8'h02, 0,0, 1,2, 1,7, 0), 32'h0012_3456, 64'h0807_0605_0403_0201, 64'h0, 3, 2, 0);
    runCmd(mkWord(8'h0B, 1,0, 1,0, 0,0, 31), 32'h0000_005A, 64'h0, 64'h0000_0000_0000_00A5, 1, 0, 0);
    runCmd(mkWord(8'h01, 0,0, 0,0, 1,0, 0), 32'h0, 64'h0000_0000_0000_0081, 64'h0, 2, 0, 0);
    runCmd(mkWord(8'h35, 1,3, 1,1, 1,4, 3), 32'hFFFF_C0DE, 64'h00_0000_5566_7788_99, 64'h0000_0000_CAFE_F00D, 2, 20, 1);
    for (int t = 0; t < 24; t++) begin
      logic [31:0] w;
      w = mkWord(8'($urandom), 1'($urandom), int'($urandom % 8), 1'($urandom), int'($urandom % 4),
                 1'($urandom), int'($urandom % 8), ($urandom % 3 == 0) ? int'($urandom % 32) : 0);
      runCmd(w, $urandom, {$urandom, $urandom}, {$urandom, $urandom},
             int'($urandom % 3) + 1, int'($urandom % 6), 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule